// File: doc/BRIEF.md
# Block-Transfer Base Write-Back Sequencer

This block steps through one load/store-multiple instruction, one register per cycle. For each register named in the instruction it issues one word-sized memory beat. It also decides whether the base register receives its write-back value, and when. The memory side answers each beat with an abort indication in the same cycle.

The decision about write-back follows one of two abort models, chosen by a static configuration input:

- **Updated model.** The base is always rewritten, early in the transfer, even if a beat aborts.
- **Restored model.** The rewrite waits until every beat has finished. It is skipped entirely if any beat aborted, so the base keeps its pre-instruction value.

Either way, every beat runs to the end, and the abort responses are merged into a sticky flag. A decode stage supplies the write-back bit, the base register index, the 16-bit register list, the start address and the precomputed write-back value. The register file consumes the base write port, and exception logic consumes the flag and the done pulse.

Top module: `lsm_wb_ctrl`

## Requirements
- R1: One beat is issued per set bit of the register list, in consecutive cycles, with `beat_reg` naming registers in ascending index order; `beat_valid` is high only during those beats.
- R2: Every beat address has its two low bits cleared; the first beat uses the start address with bits [1:0] forced to 0 and each later beat adds 4.
- R3: The base register is never written when the write-back bit (`wb_bit`, instruction bit 21) was 0 at start.
- R4: The base register is never written when the base index is 15.
- R5: With `cfg_restore`=0 (updated model) and write-back enabled, `base_we` pulses once, during the second beat cycle (or together with `done` when the list holds one register), whether or not any beat aborts.
- R6: With `cfg_restore`=1 (restored model) and write-back enabled, `base_we` pulses once, together with `done`, only if no beat aborted; after any abort the base is not written.
- R7: A `beat_abort` on any beat does not stop the remaining beats; `abort_flag` becomes the OR of all beat aborts in the `done` cycle, holds afterwards, and is cleared only when the next instruction starts.
- R8: `done` is a single-cycle pulse N+1 cycles after the start cycle for an N-register list; an empty list gives `done` one cycle after start with no beats and no write.
- R9: `base_wdata` and `base_wr_idx` carry the write-back value and base index captured at start whenever `base_we` is high.
- R10: After reset `busy`, `done`, `beat_valid`, `base_we` and `abort_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_restore | input | 1 | Abort model: 0 updated, 1 restored (static) |
| start | input | 1 | Begin an instruction; taken only while idle |
| wb_bit | input | 1 | Write-back requested (instruction bit 21) |
| base_idx | input | 4 | Base register index |
| reg_list | input | 16 | Register list, bit i selects register i |
| start_addr | input | 32 | First transfer address |
| wb_value | input | 32 | Precomputed base write-back value |
| beat_abort | input | 1 | Abort response for the current beat |
| busy | output | 1 | Instruction in progress |
| beat_valid | output | 1 | A memory beat is issued this cycle |
| beat_addr | output | 32 | Word-aligned address of the beat |
| beat_reg | output | 4 | Register index transferred by the beat |
| base_we | output | 1 | Base register write enable |
| base_wr_idx | output | 4 | Base register index for the write |
| base_wdata | output | 32 | Value written to the base register |
| abort_flag | output | 1 | Sticky data-abort flag |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:

- **Abort on the first beat in the updated model.** A design that applied the restored rule everywhere would drop the write.
- **Abort on the last beat in the restored model.** A design that wrote back before accumulating the final beat's abort would still update the base.
- **A single-register list in the updated model.** There is no second beat here, so a design keyed only to the second beat would never write.
- **An empty list.** A sloppy design would issue a spurious beat or write.
- **Base index 15.** A sloppy design would write the base anyway.
- **A misaligned start address.** A sloppy design would leak address bits [1:0].
- **The instruction after an aborted one.** A design whose flag was not truly sticky would drop it after `done`; one that never cleared it would report a stale abort on the next instruction.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    parameter int unsigned XLEN   = 32;
    parameter int unsigned NREGS  = 16;
    localparam int unsigned RIDX_W = $clog2(NREGS);
    localparam int unsigned CNT_W  = $clog2(NREGS + 1);
    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } lsm_state_e;

    typedef enum logic {
        AM_UPDATED  = 1'b0,
        AM_RESTORED = 1'b1
    } abort_model_e;

    typedef struct packed {
        logic              en;
        logic [RIDX_W-1:0] idx;
        logic [XLEN-1:0]   value;
    } base_wr_t;

    function automatic logic [XLEN-1:0] word_align(input logic [XLEN-1:0] a);
        return {a[XLEN-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/lsm_reg_pick.sv
module lsm_reg_pick #(
    parameter int unsigned NREGS  = lsm_pkg::NREGS,
    parameter int unsigned RIDX_W = lsm_pkg::RIDX_W
) (
    input  logic [NREGS-1:0]  mask,
    output logic [NREGS-1:0]  grant,
    output logic [RIDX_W-1:0] idx,
    output logic              last,
    output logic              any
);
    logic [NREGS-1:0] rest;

    // lowest set bit wins: ascending register order
    assign grant = mask & (~mask + NREGS'(1));
    assign rest  = mask & ~grant;
    assign any   = |mask;
    assign last  = any && (rest == '0);

    logic [RIDX_W-1:0] idx_terms [NREGS];

    genvar g;
    generate
        for (g = 0; g < NREGS; g++) begin : g_enc
            assign idx_terms[g] = grant[g] ? RIDX_W'(g) : '0;
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < NREGS; i++) begin
            idx = idx | idx_terms[i];
        end
    end
endmodule

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen #(
    parameter int unsigned XLEN = lsm_pkg::XLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [XLEN-1:0] load_addr,
    input  logic            step,
    output logic [XLEN-1:0] addr
);
    import lsm_pkg::*;

    logic [XLEN-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= word_align(load_addr);
        end else if (step) begin
            addr_q <= addr_q + XLEN'(WORD_BYTES);
        end
    end

    assign addr = addr_q;

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (addr_q == $past(addr_q) + XLEN'(WORD_BYTES)));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (addr_q[1:0] == 2'b00));
endmodule

// File: rtl/lsm_wb_policy.sv
module lsm_wb_policy #(
    parameter int unsigned CNT_W = lsm_pkg::CNT_W
) (
    input  logic             model_restore,
    input  logic             wb_enabled,
    input  logic             in_xfer,
    input  logic             in_fin,
    input  logic [CNT_W-1:0] beats_done,
    input  logic             any_abort,
    output logic             write_now
);
    import lsm_pkg::*;

    abort_model_e model;
    logic early_slot;
    logic late_slot;

    assign model = abort_model_e'(model_restore);

    // second beat cycle, or end of a one-register transfer
    assign early_slot = (in_xfer && beats_done == CNT_W'(1)) ||
                        (in_fin  && beats_done == CNT_W'(1));
    // end of instruction, list non-empty, nothing aborted
    assign late_slot  = in_fin && (beats_done != '0) && !any_abort;

    always_comb begin
        unique case (model)
            AM_UPDATED:  write_now = wb_enabled && early_slot;
            AM_RESTORED: write_now = wb_enabled && late_slot;
            default:     write_now = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsm_wb_ctrl.sv
module lsm_wb_ctrl #(
    parameter int unsigned XLEN   = lsm_pkg::XLEN,
    parameter int unsigned NREGS  = lsm_pkg::NREGS,
    localparam int unsigned RIDX_W = $clog2(NREGS),
    localparam int unsigned CNT_W  = $clog2(NREGS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_restore,
    input  logic              start,
    input  logic              wb_bit,
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [NREGS-1:0]  reg_list,
    input  logic [XLEN-1:0]   start_addr,
    input  logic [XLEN-1:0]   wb_value,
    input  logic              beat_abort,
    output logic              busy,
    output logic              beat_valid,
    output logic [XLEN-1:0]   beat_addr,
    output logic [RIDX_W-1:0] beat_reg,
    output logic              base_we,
    output logic [RIDX_W-1:0] base_wr_idx,
    output logic [XLEN-1:0]   base_wdata,
    output logic              abort_flag,
    output logic              done
);
    import lsm_pkg::*;

    localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(NREGS - 1);

    lsm_state_e        state_q;
    logic [NREGS-1:0]  mask_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              acc_q;
    logic              flag_q;
    logic              wb_en_q;
    logic [RIDX_W-1:0] base_q;
    logic [XLEN-1:0]   val_q;

    logic              start_acc;
    logic              in_xfer;
    logic              in_fin;
    logic [NREGS-1:0]  grant;
    logic [RIDX_W-1:0] pick_idx;
    logic              pick_last;
    logic              pick_any;
    logic              wr_now;
    base_wr_t          wr;

    assign start_acc = start && (state_q == ST_IDLE);
    assign in_xfer   = (state_q == ST_XFER);
    assign in_fin    = (state_q == ST_FIN);

    lsm_reg_pick #(.NREGS(NREGS), .RIDX_W(RIDX_W)) u_pick (
        .mask  (mask_q),
        .grant (grant),
        .idx   (pick_idx),
        .last  (pick_last),
        .any   (pick_any)
    );

    lsm_addr_gen #(.XLEN(XLEN)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (start_acc),
        .load_addr (start_addr),
        .step      (in_xfer),
        .addr      (beat_addr)
    );

    lsm_wb_policy #(.CNT_W(CNT_W)) u_policy (
        .model_restore (cfg_restore),
        .wb_enabled    (wb_en_q),
        .in_xfer       (in_xfer),
        .in_fin        (in_fin),
        .beats_done    (cnt_q),
        .any_abort     (acc_q),
        .write_now     (wr_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            cnt_q   <= '0;
            acc_q   <= 1'b0;
            flag_q  <= 1'b0;
            wb_en_q <= 1'b0;
            base_q  <= '0;
            val_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mask_q  <= reg_list;
                        cnt_q   <= '0;
                        acc_q   <= 1'b0;
                        flag_q  <= 1'b0;
                        wb_en_q <= wb_bit && (base_idx != PC_IDX);
                        base_q  <= base_idx;
                        val_q   <= wb_value;
                        state_q <= (reg_list == '0) ? ST_FIN : ST_XFER;
                    end
                end
                ST_XFER: begin
                    mask_q <= mask_q & ~grant;
                    cnt_q  <= cnt_q + CNT_W'(1);
                    acc_q  <= acc_q | beat_abort;
                    if (pick_last) begin
                        flag_q  <= acc_q | beat_abort;
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wr.en    = wr_now;
    assign wr.idx   = base_q;
    assign wr.value = val_q;

    assign busy        = (state_q != ST_IDLE);
    assign beat_valid  = in_xfer && pick_any;
    assign beat_reg    = pick_idx;
    assign base_we     = wr.en;
    assign base_wr_idx = wr.idx;
    assign base_wdata  = wr.value;
    assign abort_flag  = flag_q;
    assign done        = in_fin;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    beat_align_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_addr[1:0] == 2'b00));

    // R4
    no_pc_write_chk: assert property (@(posedge clk) disable iff (rst)
        base_we |-> (base_wr_idx != PC_IDX));

    // R6
    restore_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_restore && base_we) |-> (done && !abort_flag));

    // R5
    update_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_restore && base_we) |-> (beat_valid || done));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_flag && !start_acc) |=> abort_flag);

    // R1
    beat_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> $onehot0(grant));
endmodule

// File: tb/lsm_wb_ctrl_test.sv
`timescale 1ns/1ps
module lsm_wb_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_restore;
    logic        start;
    logic        wb_bit;
    logic [3:0]  base_idx;
    logic [15:0] reg_list;
    logic [31:0] start_addr;
    logic [31:0] wb_value;
    logic        beat_abort;
    logic        busy, beat_valid, base_we, abort_flag, done;
    logic [31:0] beat_addr, base_wdata;
    logic [3:0]  beat_reg, base_wr_idx;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lsm_wb_ctrl uut (
        .clk(clk), .rst(rst), .cfg_restore(cfg_restore), .start(start),
        .wb_bit(wb_bit), .base_idx(base_idx), .reg_list(reg_list),
        .start_addr(start_addr), .wb_value(wb_value), .beat_abort(beat_abort),
        .busy(busy), .beat_valid(beat_valid), .beat_addr(beat_addr),
        .beat_reg(beat_reg), .base_we(base_we), .base_wr_idx(base_wr_idx),
        .base_wdata(base_wdata), .abort_flag(abort_flag), .done(done)
    );

    // {restore, wb, idx[3:0], list[15:0], addr[31:0], aborts[15:0]}
    localparam int NV = 9;
    localparam logic [69:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'd3,  16'h00F0, 32'h0000_1000, 16'h0000},
        {1'b0, 1'b1, 4'd3,  16'h8421, 32'h0000_2003, 16'h0001},
        {1'b1, 1'b1, 4'd5,  16'h0F00, 32'h0000_3000, 16'h0000},
        {1'b1, 1'b1, 4'd5,  16'h0007, 32'h0000_4002, 16'h0004},
        {1'b1, 1'b0, 4'd2,  16'h0003, 32'h0000_5000, 16'h0000},
        {1'b0, 1'b1, 4'd15, 16'h0006, 32'h0000_6000, 16'h0000},
        {1'b0, 1'b1, 4'd7,  16'h0010, 32'h0000_7001, 16'h0000},
        {1'b1, 1'b1, 4'd9,  16'hFFFF, 32'h0000_8000, 16'h0000},
        {1'b0, 1'b1, 4'd1,  16'h0000, 32'h0000_9000, 16'h0000}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int nth_reg(input logic [15:0] list, input int n);
        int seen = 0;
        for (int i = 0; i < 16; i++) begin
            if (list[i]) begin
                if (seen == n) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    task automatic run_one(input logic [69:0] v, input logic [31:0] wval);
        logic        rs   = v[69];
        logic        wb   = v[68];
        logic [3:0]  idx  = v[67:64];
        logic [15:0] lst  = v[63:48];
        logic [31:0] adr  = v[47:16];
        logic [15:0] abs  = v[15:0];
        int n = $countones(lst);
        bit wb_ok = wb && (idx != 4'd15) && (n > 0);
        bit any_ab = 1'b0;
        int exp_we_cyc;
        int we_cnt = 0, we_cyc = 0, done_cyc = 0, beats = 0;
        logic flag_at_done = 1'b0;
        for (int b = 0; b < n; b++) if (abs[b]) any_ab = 1'b1;
        if (!wb_ok) exp_we_cyc = 0;
        else if (!rs) exp_we_cyc = 2;
        else exp_we_cyc = any_ab ? 0 : n + 1;

        cfg_restore = rs; wb_bit = wb; base_idx = idx; reg_list = lst;
        start_addr = adr; wb_value = wval; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int cyc = 1; cyc <= 20; cyc++) begin
            beat_abort = 1'b0;
            if (beat_valid) begin
                // R1 / R2
                check(beat_reg == 4'(nth_reg(lst, beats)), "R1", "beat_reg",
                      32'(beat_reg), 32'(nth_reg(lst, beats)));
                check(beat_addr == {adr[31:2], 2'b00} + 32'(4 * beats), "R2",
                      "beat_addr", beat_addr, {adr[31:2], 2'b00} + 32'(4 * beats));
                beat_abort = abs[beats];
                beats++;
            end
            if (base_we) begin
                we_cnt++; we_cyc = cyc;
                check(base_wdata == wval && base_wr_idx == idx, "R9", "base write",
                      base_wdata, wval);
            end
            if (done) begin
                done_cyc = cyc;
                flag_at_done = abort_flag;
                check(!beat_valid, "R1", "beat_valid at done", 32'(beat_valid), 0);
                break;
            end
            @(posedge clk); @(negedge clk);
        end
        beat_abort = 1'b0;
        check(beats == n, "R7", "beat count", beats, n);
        check(done_cyc == n + 1, "R8", "done cycle", done_cyc, n + 1);
        check(flag_at_done == any_ab, "R7", "flag at done", 32'(flag_at_done), 32'(any_ab));
        if (!wb) check(we_cnt == 0, "R3", "write with wb=0", we_cnt, 0);
        else if (idx == 4'd15) check(we_cnt == 0, "R4", "write to r15", we_cnt, 0);
        else if (!rs) check(we_cnt == (n > 0) && we_cyc == exp_we_cyc, "R5",
                            "updated write cycle", we_cyc, exp_we_cyc);
        else check(we_cnt == (exp_we_cyc != 0) && we_cyc == exp_we_cyc, "R6",
                   "restored write cycle", we_cyc, exp_we_cyc);
        @(posedge clk); @(negedge clk);
        check(!done && !busy, "R8", "done single pulse", 32'(done), 0);
        check(abort_flag == any_ab, "R7", "flag held", 32'(abort_flag), 32'(any_ab));
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; cfg_restore = 1'b0; wb_bit = 1'b0;
        base_idx = '0; reg_list = '0; start_addr = '0; wb_value = '0;
        beat_abort = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(!busy && !done && !beat_valid && !base_we && !abort_flag, "R10",
              "reset outputs", {27'd0, busy, done, beat_valid, base_we, abort_flag}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_one(VEC[k], 32'hA500_0000 + 32'(k));
        end

        // R7: updated model, abort on the middle beat, next start clears flag
        run_one({1'b0, 1'b1, 4'd4, 16'h0111, 32'h0000_A000, 16'h0002}, 32'hBEEF_0001);
        run_one({1'b1, 1'b1, 4'd4, 16'h0030, 32'h0000_B000, 16'h0000}, 32'hBEEF_0002);
        // R6: restored model, abort on first of two beats
        run_one({1'b1, 1'b1, 4'd6, 16'h0300, 32'h0000_C000, 16'h0001}, 32'hBEEF_0003);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule